// File: doc/BRIEF.md
# Dual-Mode Interrupt Pending Aggregator

This block gathers interrupt causes into one pending vector and turns them into a notification for a host. Causes arrive from two places. Internal completion sources assert one-cycle done strobes. Software writes a bit mask either to a set offset or to a clear offset of a small register window. The pending vector can be read back through the same window.

The notification form depends on the `msi_en` input. When `msi_en` is low, the block drives a level interrupt line. The line rises when a set leaves bits pending. It falls only when a clear empties the vector. When `msi_en` is high, the block instead emits a one-clock message pulse for each set event that leaves the vector non-zero, and a clear never produces a message.

The two paths are deliberately asymmetric. A set always re-notifies, even when the bits it names were already pending. A clear only ever withdraws the level line.

Top module: `irq_agg_top`

## Requirements
- R1: After reset the pending vector reads zero and `intx`, `msi_pulse` and `rd_valid` are low.
- R2: A write to offset 0x60 ORs `wr_data` into the pending vector, effective at the clock edge that samples the write.
- R3: A write to offset 0x64 clears every pending bit that is 1 in `wr_data`.
- R4: A strobe on `hw_done[0]` (compute done) sets pending bit 0, and a strobe on `hw_done[1]` (DMA done) sets pending bit 8.
- R5: A read with `rd_en` high returns, one cycle later with `rd_valid` high, the pending vector as it stood before that edge when `rd_addr` is 0x24, and all ones for any other offset.
- R6: With `msi_en` low, a set event that leaves the vector non-zero drives `intx` high from the next cycle on.
- R7: With `msi_en` low, a clear drops `intx` only when the vector becomes zero; a partial clear leaves `intx` high.
- R8: With `msi_en` high, every set event that leaves the vector non-zero gives exactly one cycle of `msi_pulse`, even when its bits were already pending, and does not raise `intx`.
- R9: A clear never produces `msi_pulse`, and with `msi_en` high a clear leaves `intx` unchanged.
- R10: When a hardware strobe and a software clear hit the same bit in one cycle, the bit ends up set.
- R11: A write of an all-zero mask to the set offset counts as a set event: it re-notifies when bits are pending and does nothing when the vector is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msi_en | input | 1 | Selects message pulses (1) or level line (0) |
| hw_done | input | N_HW (2) | One-cycle done strobes from internal sources |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (8) | Register write offset |
| wr_data | input | VEC_W (32) | Register write mask |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W (8) | Register read offset |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | VEC_W (32) | Read data |
| intx | output | 1 | Level interrupt line |
| msi_pulse | output | 1 | One-cycle message interrupt pulse |

## Verification
The bench uses the default parameters: a 32-bit vector, two hardware sources mapped to bits 0 and 8, and the offsets 0x60, 0x64 and 0x24. With these values, full-width masks up to bit 31 can be written and cleared in one access. Both source positions can be hit, including a DMA strobe that coincides with a clear of the same bit. The runs switch `msi_en` while bits are pending, so they cover the case where a level line raised in one mode survives a clear issued in the other mode.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    typedef enum logic [1:0] {
        WK_NONE  = 2'd0,
        WK_SET   = 2'd1,
        WK_CLEAR = 2'd2
    } wr_kind_e;

endpackage

// File: rtl/irq_agg_wdec.sv
module irq_agg_wdec
    import irq_agg_pkg::*;
#(
    parameter int unsigned           ADDR_W  = 8,
    parameter int unsigned           VEC_W   = 32,
    parameter logic [ADDR_W-1:0]     SET_OFS = 8'h60,
    parameter logic [ADDR_W-1:0]     CLR_OFS = 8'h64
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [VEC_W-1:0]  wr_data,
    output wr_kind_e          kind,
    output logic [VEC_W-1:0]  mask
);

    always_comb begin
        kind = WK_NONE;
        mask = '0;
        if (wr_en) begin
            if (wr_addr == SET_OFS) begin
                kind = WK_SET;
                mask = wr_data;
            end else if (wr_addr == CLR_OFS) begin
                kind = WK_CLEAR;
                mask = wr_data;
            end
        end
    end

endmodule

// File: rtl/irq_agg_hwmap.sv
module irq_agg_hwmap #(
    parameter int unsigned              N_HW    = 2,
    parameter int unsigned              VEC_W   = 32,
    parameter logic [N_HW*8-1:0]        HW_BITS = 16'h0800
) (
    input  logic [N_HW-1:0]  hw_done,
    output logic [VEC_W-1:0] hw_mask,
    output logic             hw_any
);

    logic [VEC_W-1:0] src_vec [N_HW];

    for (genvar g = 0; g < N_HW; g++) begin : g_src
        localparam int unsigned POS = int'(HW_BITS[g*8 +: 8]);
        assign src_vec[g] = hw_done[g] ? (VEC_W'(1) << POS) : '0;
    end

    always_comb begin
        hw_mask = '0;
        for (int i = 0; i < N_HW; i++) begin
            hw_mask = hw_mask | src_vec[i];
        end
    end

    assign hw_any = |hw_done;

endmodule

// File: rtl/irq_agg_notify.sv
module irq_agg_notify #(
    parameter int unsigned VEC_W = 32
) (
    input  logic             set_ev,
    input  logic             clr_ev,
    input  logic [VEC_W-1:0] pend_next,
    input  logic             msi_en,
    input  logic             intx_cur,
    output logic             intx_next,
    output logic             msi_next
);

    logic nonzero;
    assign nonzero = |pend_next;

    always_comb begin
        intx_next = intx_cur;
        msi_next  = 1'b0;
        if (set_ev && nonzero) begin
            if (msi_en) begin
                msi_next = 1'b1;
            end else begin
                intx_next = 1'b1;
            end
        end else if (clr_ev && !nonzero && !msi_en) begin
            intx_next = 1'b0;
        end
    end

endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
    import irq_agg_pkg::*;
#(
    parameter int unsigned           VEC_W    = 32,
    parameter int unsigned           ADDR_W   = 8,
    parameter int unsigned           N_HW     = 2,
    parameter logic [N_HW*8-1:0]     HW_BITS  = 16'h0800,
    parameter logic [ADDR_W-1:0]     SET_OFS  = 8'h60,
    parameter logic [ADDR_W-1:0]     CLR_OFS  = 8'h64,
    parameter logic [ADDR_W-1:0]     STAT_OFS = 8'h24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msi_en,
    input  logic [N_HW-1:0]   hw_done,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [VEC_W-1:0]  wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_valid,
    output logic [VEC_W-1:0]  rd_data,
    output logic              intx,
    output logic              msi_pulse
);

    typedef struct packed {
        logic [VEC_W-1:0] pend;
        logic             intx;
        logic             msi;
        logic             rd_valid;
        logic [VEC_W-1:0] rd_data;
    } agg_state_t;

    agg_state_t st_d, st_q;

    wr_kind_e         wk;
    logic [VEC_W-1:0] sw_mask;
    logic [VEC_W-1:0] hw_mask;
    logic             hw_any;
    logic [VEC_W-1:0] set_mask;
    logic [VEC_W-1:0] clr_mask;
    logic             set_ev;
    logic             clr_ev;
    logic [VEC_W-1:0] pend_next;
    logic             intx_next;
    logic             msi_next;

    irq_agg_wdec #(
        .ADDR_W  (ADDR_W),
        .VEC_W   (VEC_W),
        .SET_OFS (SET_OFS),
        .CLR_OFS (CLR_OFS)
    ) u_wdec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .kind    (wk),
        .mask    (sw_mask)
    );

    irq_agg_hwmap #(
        .N_HW    (N_HW),
        .VEC_W   (VEC_W),
        .HW_BITS (HW_BITS)
    ) u_hwmap (
        .hw_done (hw_done),
        .hw_mask (hw_mask),
        .hw_any  (hw_any)
    );

    always_comb begin
        set_ev    = hw_any || (wk == WK_SET);
        clr_ev    = (wk == WK_CLEAR);
        set_mask  = hw_mask | ((wk == WK_SET) ? sw_mask : '0);
        clr_mask  = (wk == WK_CLEAR) ? sw_mask : '0;
        // set wins over a same-cycle clear on overlapping bits
        pend_next = (st_q.pend & ~clr_mask) | set_mask;
    end

    irq_agg_notify #(
        .VEC_W (VEC_W)
    ) u_notify (
        .set_ev    (set_ev),
        .clr_ev    (clr_ev),
        .pend_next (pend_next),
        .msi_en    (msi_en),
        .intx_cur  (st_q.intx),
        .intx_next (intx_next),
        .msi_next  (msi_next)
    );

    always_comb begin
        st_d          = st_q;
        st_d.pend     = pend_next;
        st_d.intx     = intx_next;
        st_d.msi      = msi_next;
        st_d.rd_valid = rd_en;
        if (rd_en) begin
            st_d.rd_data = (rd_addr == STAT_OFS) ? st_q.pend : '1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_valid  = st_q.rd_valid;
    assign rd_data   = st_q.rd_data;
    assign intx      = st_q.intx;
    assign msi_pulse = st_q.msi;

endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
    parameter int unsigned           VEC_W   = 32,
    parameter int unsigned           ADDR_W  = 8,
    parameter int unsigned           N_HW    = 2,
    parameter logic [N_HW*8-1:0]     HW_BITS = 16'h0800,
    parameter logic [ADDR_W-1:0]     SET_OFS = 8'h60,
    parameter logic [ADDR_W-1:0]     CLR_OFS = 8'h64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              msi_en,
    input logic [N_HW-1:0]   hw_done,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [VEC_W-1:0]  wr_data,
    input logic              intx,
    input logic              msi_pulse,
    input logic [VEC_W-1:0]  pend
);

    localparam int unsigned POS0 = int'(HW_BITS[7:0]);

    logic sw_set, sw_clr_only;
    assign sw_set      = wr_en && (wr_addr == SET_OFS);
    assign sw_clr_only = wr_en && (wr_addr == CLR_OFS) && (hw_done == '0);

    p_set_or_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sw_set |=> ((pend & $past(wr_data)) == $past(wr_data)));

    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sw_clr_only |=> ((pend & $past(wr_data)) == '0));

    p_hw0_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hw_done[0] |=> pend[POS0]);

    p_intx_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(intx) |-> ((pend != '0) && !$past(msi_en)));

    p_intx_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(intx) |-> ((pend == '0) && !$past(msi_en)));

    p_msi_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        msi_pulse |-> ($past(msi_en) && (pend != '0)));

    p_clear_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sw_clr_only |=> !msi_pulse);

endmodule

bind irq_agg_top irq_agg_chk #(
    .VEC_W   (VEC_W),
    .ADDR_W  (ADDR_W),
    .N_HW    (N_HW),
    .HW_BITS (HW_BITS),
    .SET_OFS (SET_OFS),
    .CLR_OFS (CLR_OFS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .msi_en    (msi_en),
    .hw_done   (hw_done),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .intx      (intx),
    .msi_pulse (msi_pulse),
    .pend      (st_q.pend)
);

// File: tb/irq_agg_top_tb_top.sv
module irq_agg_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msi_en = 1'b0;
    logic [1:0]  hw_done = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_addr = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        intx;
    logic        msi_pulse;

    always #2 clk = ~clk;

    irq_agg_top dut_i (
        .clk(clk), .rst_n(rst_n), .msi_en(msi_en), .hw_done(hw_done),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid),
        .rd_data(rd_data), .intx(intx), .msi_pulse(msi_pulse)
    );

    typedef struct {
        bit          intx;
        bit          msi;
        bit          rdv;
        logic [31:0] rd;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    int          checks = 0;
    int          errors = 0;
    logic [31:0] m_pend = '0;
    bit          m_intx = 1'b0;
    bit          done = 1'b0;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // driver: one clock edge per call, expected result pushed to scoreboard
    task automatic step(input bit wr, input logic [7:0] wa, input logic [31:0] wd,
                        input bit rd, input logic [7:0] ra, input logic [1:0] hw,
                        input bit me, input string tag);
        exp_t        e;
        logic [31:0] setm, clrm, pn;
        bit          sev, cev;
        @(negedge clk);
        wr_en = wr; wr_addr = wa; wr_data = wd;
        rd_en = rd; rd_addr = ra; hw_done = hw; msi_en = me;
        sev  = (wr && wa == 8'h60) || (hw != 2'b00);
        cev  = wr && wa == 8'h64;
        setm = ((wr && wa == 8'h60) ? wd : 32'h0)
             | (hw[0] ? 32'h1 : 32'h0) | (hw[1] ? 32'h100 : 32'h0);
        clrm = cev ? wd : 32'h0;
        pn   = (m_pend & ~clrm) | setm;
        e.rdv = rd;
        e.rd  = (ra == 8'h24) ? m_pend : 32'hFFFF_FFFF;
        e.msi = sev && (pn != 0) && me;
        if (sev && pn != 0 && !me)       m_intx = 1'b1;
        else if (cev && pn == 0 && !me)  m_intx = 1'b0;
        e.intx = m_intx;
        e.tag  = tag;
        m_pend = pn;
        sb_q.push_back(e);
    endtask

    task automatic idle(input bit me, input string tag);
        step(1'b0, 8'h00, 32'h0, 1'b0, 8'h00, 2'b00, me, tag);
    endtask

    // monitor: pops one expectation per edge
    initial begin
        exp_t e;
        @(posedge rst_n);
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                e = sb_q.pop_front();
                chk(e.tag, "intx", {31'b0, intx}, {31'b0, e.intx});
                chk(e.tag, "msi_pulse", {31'b0, msi_pulse}, {31'b0, e.msi});
                chk(e.tag, "rd_valid", {31'b0, rd_valid}, {31'b0, e.rdv});
                if (e.rdv) chk(e.tag, "rd_data", rd_data, e.rd);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", "intx", {31'b0, intx}, 32'h0);
        chk("R1", "msi_pulse", {31'b0, msi_pulse}, 32'h0);
        chk("R1", "rd_valid", {31'b0, rd_valid}, 32'h0);
        step(1'b0, 8'h00, 32'h0, 1'b1, 8'h24, 2'b00, 1'b0, "R1");

        // level mode
        step(1'b1, 8'h60, 32'h0000_0005, 1'b0, 8'h00, 2'b00, 1'b0, "R2_R6");
        step(1'b0, 8'h00, 32'h0, 1'b1, 8'h24, 2'b00, 1'b0, "R5");
        step(1'b1, 8'h64, 32'h0000_0001, 1'b0, 8'h00, 2'b00, 1'b0, "R3_R7");
        step(1'b0, 8'h00, 32'h0, 1'b1, 8'h28, 2'b00, 1'b0, "R5");
        step(1'b1, 8'h64, 32'h0000_0004, 1'b1, 8'h24, 2'b00, 1'b0, "R7");
        step(1'b0, 8'h00, 32'h0, 1'b1, 8'h24, 2'b01, 1'b0, "R4_R6");
        step(1'b0, 8'h00, 32'h0, 1'b0, 8'h00, 2'b10, 1'b0, "R4");
        step(1'b0, 8'h00, 32'h0, 1'b1, 8'h24, 2'b00, 1'b0, "R4");
        step(1'b1, 8'h60, 32'h8000_0000, 1'b0, 8'h00, 2'b00, 1'b0, "R2");
        step(1'b1, 8'h64, 32'hFFFF_FFFF, 1'b1, 8'h24, 2'b00, 1'b0, "R7");
        step(1'b1, 8'h64, 32'h0000_0100, 1'b0, 8'h00, 2'b10, 1'b0, "R10");
        step(1'b0, 8'h00, 32'h0, 1'b1, 8'h24, 2'b00, 1'b0, "R10");
        step(1'b1, 8'h64, 32'h0000_0100, 1'b0, 8'h00, 2'b00, 1'b0, "R7");
        step(1'b1, 8'h60, 32'h0, 1'b0, 8'h00, 2'b00, 1'b0, "R11");

        // message mode
        step(1'b1, 8'h60, 32'h0000_0002, 1'b0, 8'h00, 2'b00, 1'b1, "R8");
        step(1'b1, 8'h60, 32'h0000_0002, 1'b0, 8'h00, 2'b00, 1'b1, "R8");
        idle(1'b1, "R8");
        step(1'b1, 8'h60, 32'h0, 1'b0, 8'h00, 2'b00, 1'b1, "R11");
        step(1'b1, 8'h64, 32'h0000_0002, 1'b1, 8'h24, 2'b00, 1'b1, "R9");
        step(1'b1, 8'h60, 32'h0, 1'b1, 8'h24, 2'b00, 1'b1, "R11");
        step(1'b0, 8'h00, 32'h0, 1'b0, 8'h00, 2'b01, 1'b1, "R8_R4");
        step(1'b0, 8'h00, 32'h0, 1'b0, 8'h00, 2'b01, 1'b1, "R8");
        step(1'b1, 8'h64, 32'hFFFF_FFFF, 1'b0, 8'h00, 2'b00, 1'b1, "R9");

        // level raised, then cleared while messages are selected
        step(1'b1, 8'h60, 32'h0000_0010, 1'b0, 8'h00, 2'b00, 1'b0, "R6");
        step(1'b1, 8'h64, 32'hFFFF_FFFF, 1'b1, 8'h24, 2'b00, 1'b1, "R9");
        step(1'b0, 8'h00, 32'h0, 1'b1, 8'h24, 2'b00, 1'b1, "R9");
        step(1'b1, 8'h60, 32'h0000_0020, 1'b0, 8'h00, 2'b00, 1'b0, "R6");
        step(1'b1, 8'h64, 32'h0000_0020, 1'b0, 8'h00, 2'b00, 1'b0, "R7");
        idle(1'b0, "R7");
        idle(1'b0, "R7");

        while (sb_q.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule